// File: doc/BRIEF.md
# JTAG Test Access Port with Switchable Serial Data Input

This block is a boundary-scan test access port: a sixteen-state TAP controller clocked by TCK. It has a four-bit instruction register, a 32-bit identification register and a one-bit bypass register. Serial data can enter from either of two pins, a primary TDI or an alternate TDI. A select pin and an internal latch decide which one is live.

The select pin picks the input directly. High means primary, and a low level forces the alternate pin. With the select pin high, a tester that drives only TMS and TCK can still move the port onto the alternate pin. It does this by completing the same identification instruction in four Update-IR passes in a row. After that, the primary pin is ignored until the controller next passes through Test-Logic-Reset. This lets a board route test data around a section of the scan chain that has no power. A status output reports which input is live.

Top module: `jtag_tap_altsel`

## Requirements
- R1: While `trst_n` is low, and after it is released, the controller sits in Test-Logic-Reset with `tdo_oe` = 0, `tdo` = 0 and `alt_active` = 0 when `tdi_sel` = 1.
- R2: State changes follow the standard TAP transitions on rising TCK. Five rising edges with TMS = 1 reach Test-Logic-Reset from any state.
- R3: `tdi_sel` = 1 makes `tdi` the serial input and `tdi_sel` = 0 makes `tdi_alt` the serial input. `alt_active` is 1 exactly when `tdi_alt` is live. An undriven select input counts as 1.
- R4: Capture-IR loads 4'b0001 and Shift-IR moves bits toward TDO LSB first. Opcode 4'b0001 selects the identification register and every other opcode, 4'b1111 included, selects bypass. Test-Logic-Reset loads 4'b0001.
- R5: With the identification opcode, Shift-DR returns the 32-bit ID (default 32'h2B6D_904F, bit 0 always 1) LSB first. Nothing on either data pin affects it.
- R6: The bypass register captures 0 in Capture-DR, so a Shift-DR scan returns 0 followed by the live input delayed by one cycle.
- R7: TDO and its enable change on falling TCK. `tdo_oe` is 1 only in Shift-IR and Shift-DR.
- R8: With `tdi_sel` high, four Update-IR passes in a row that each load 4'b0001 set `alt_active` to 1. An Update-IR that loads any other opcode restarts the run.
- R9: Once set by that run, `alt_active` stays 1 and the primary pin has no effect, across any later instructions, until Test-Logic-Reset. Test-Logic-Reset clears both the latch and the run count. The opcode loaded by reset does not count toward the run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test reset, active low, asynchronous assert |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Primary serial data input |
| tdi_alt | input | 1 | Alternate serial data input |
| tdi_sel | input | 1 | Input select: 1 primary, 0 alternate; undriven reads as 1 |
| tdo | output | 1 | Serial data output |
| tdo_oe | output | 1 | Output enable for tdo |
| alt_active | output | 1 | 1 when tdi_alt is the live serial input |

## Verification
The bench builds the port with its defaults: a 4-bit instruction register, the 32-bit ID 32'h2B6D_904F, and a run length of four identification loads. With a run length of four, the threshold is crossed after a handful of instruction scans. That brings in runs that stop one short, runs broken by a bypass opcode, and runs that start just after a reset. The narrow instruction register lets every opcode class be scanned and read back in a few cycles. The bypass scans drive different patterns on the two data pins, so any scan output shows which pin the port is actually listening to.

// File: rtl/jtag_alt_pkg.sv
`timescale 1ns/1ps
package jtag_alt_pkg;
  typedef enum logic [3:0] {
    ST_RESET  = 4'd0,
    ST_IDLE   = 4'd1,
    ST_SEL_DR = 4'd2,
    ST_CAP_DR = 4'd3,
    ST_SH_DR  = 4'd4,
    ST_EX1_DR = 4'd5,
    ST_PAU_DR = 4'd6,
    ST_EX2_DR = 4'd7,
    ST_UPD_DR = 4'd8,
    ST_SEL_IR = 4'd9,
    ST_CAP_IR = 4'd10,
    ST_SH_IR  = 4'd11,
    ST_EX1_IR = 4'd12,
    ST_PAU_IR = 4'd13,
    ST_EX2_IR = 4'd14,
    ST_UPD_IR = 4'd15
  } tap_state_e;
endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
  import jtag_alt_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);
  tap_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RESET:  st_d = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   st_d = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: st_d = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: st_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  st_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: st_d = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: st_d = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: st_d = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: st_d = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: st_d = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: st_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  st_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: st_d = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: st_d = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: st_d = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: st_d = tms ? ST_SEL_DR : ST_IDLE;
      default:   st_d = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RESET;
    else        st_q <= st_d;
  end

  assign state = st_q;
endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/1ps
module tap_ir
  import jtag_alt_pkg::*;
#(
  parameter int unsigned IR_W     = 4,
  parameter logic [IR_W-1:0] CAP_VAL  = IR_W'(1),
  parameter logic [IR_W-1:0] RESET_OP = IR_W'(1)
) (
  input  logic            tck,
  input  logic            rst_n,
  input  tap_state_e      state,
  input  logic            din,
  output logic [IR_W-1:0] ir_sr,
  output logic [IR_W-1:0] ir_q
);
  logic [IR_W-1:0] sr_q, sr_d, op_q, op_d;
  logic            sr_en, op_en;

  always_comb begin
    sr_d  = sr_q;
    sr_en = 1'b0;
    if (state == ST_CAP_IR) begin
      sr_d  = CAP_VAL;
      sr_en = 1'b1;
    end else if (state == ST_SH_IR) begin
      sr_d  = {din, sr_q[IR_W-1:1]};
      sr_en = 1'b1;
    end
  end

  always_comb begin
    op_d  = op_q;
    op_en = 1'b0;
    if (state == ST_RESET) begin
      op_d  = RESET_OP;
      op_en = 1'b1;
    end else if (state == ST_UPD_IR) begin
      op_d  = sr_q;
      op_en = 1'b1;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     sr_q <= CAP_VAL;
    else if (sr_en) sr_q <= sr_d;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     op_q <= RESET_OP;
    else if (op_en) op_q <= op_d;
  end

  assign ir_sr = sr_q;
  assign ir_q  = op_q;
endmodule

// File: rtl/tap_dr.sv
`timescale 1ns/1ps
module tap_dr
  import jtag_alt_pkg::*;
#(
  parameter int unsigned     IR_W      = 4,
  parameter logic [IR_W-1:0] OP_IDCODE = IR_W'(1),
  parameter int unsigned     ID_W      = 32,
  parameter logic [ID_W-1:0] ID_VAL    = 32'h2B6D_904F
) (
  input  logic            tck,
  input  logic            rst_n,
  input  tap_state_e      state,
  input  logic [IR_W-1:0] ir_q,
  input  logic            din,
  output logic            dr_lsb
);
  localparam logic [ID_W-1:0] ID_EFF = {ID_VAL[ID_W-1:1], 1'b1};

  logic            pick_id, cap, sh;
  logic [ID_W-1:0] id_q, id_d;
  logic            byp_q, byp_d;
  logic            id_en, byp_en;

  assign pick_id = (ir_q == OP_IDCODE);
  assign cap     = (state == ST_CAP_DR);
  assign sh      = (state == ST_SH_DR);

  always_comb begin
    id_d  = id_q;
    if (cap)     id_d = ID_EFF;
    else if (sh) id_d = {din, id_q[ID_W-1:1]};
    id_en = pick_id & (cap | sh);
  end

  always_comb begin
    byp_d  = byp_q;
    if (cap)     byp_d = 1'b0;
    else if (sh) byp_d = din;
    byp_en = ~pick_id & (cap | sh);
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     id_q <= ID_EFF;
    else if (id_en) id_q <= id_d;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      byp_q <= 1'b0;
    else if (byp_en) byp_q <= byp_d;
  end

  assign dr_lsb = pick_id ? id_q[0] : byp_q;
endmodule

// File: rtl/alt_sel.sv
`timescale 1ns/1ps
module alt_sel
  import jtag_alt_pkg::*;
#(
  parameter int unsigned     IR_W      = 4,
  parameter logic [IR_W-1:0] OP_IDCODE = IR_W'(1),
  parameter int unsigned     RUNS      = 4
) (
  input  logic            tck,
  input  logic            rst_n,
  input  tap_state_e      state,
  input  logic [IR_W-1:0] ir_sr,
  input  logic            sel_hi,
  input  logic            tdi,
  input  logic            tdi_alt,
  output logic            din,
  output logic            alt_active,
  output logic            latched
);
  localparam int unsigned CNT_W = $clog2(RUNS + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lat_q, lat_d;
  logic             upd_en, is_id;

  assign is_id = (ir_sr == OP_IDCODE);

  always_comb begin
    cnt_d  = cnt_q;
    lat_d  = lat_q;
    upd_en = 1'b0;
    if (state == ST_RESET) begin
      cnt_d  = '0;
      lat_d  = 1'b0;
      upd_en = 1'b1;
    end else if (state == ST_UPD_IR) begin
      upd_en = 1'b1;
      if (!is_id) begin
        cnt_d = '0;
      end else if (sel_hi && (cnt_q != CNT_W'(RUNS))) begin
        cnt_d = cnt_q + CNT_W'(1);
        if (cnt_q == CNT_W'(RUNS - 1)) lat_d = 1'b1;
      end
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lat_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      lat_q <= lat_d;
    end
  end

  assign alt_active = lat_q | ~sel_hi;
  assign din        = alt_active ? tdi_alt : tdi;
  assign latched    = lat_q;
endmodule

// File: rtl/jtag_tap_altsel.sv
`timescale 1ns/1ps
module jtag_tap_altsel
  import jtag_alt_pkg::*;
#(
  parameter int unsigned IR_W    = 4,
  parameter int unsigned ID_W    = 32,
  parameter logic [ID_W-1:0] ID_VAL = 32'h2B6D_904F,
  parameter int unsigned ID_RUNS = 4
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  input  logic tdi_alt,
  input  logic tdi_sel,
  output logic tdo,
  output logic tdo_oe,
  output logic alt_active
);
  localparam logic [IR_W-1:0] OP_IDCODE = IR_W'(1);
  localparam logic [IR_W-1:0] IR_CAP    = IR_W'(1);

  logic            rs_q1, rs_q2, rst_n_i;
  tap_state_e      tap_st;
  logic [IR_W-1:0] ir_sr, ir_q;
  logic            din, dr_lsb, alt_latched, sel_hi;
  logic            sh_ir, sh_dr, tdo_d, tdo_q, oe_q;

  // async assert, release aligned to TCK
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end
  assign rst_n_i = rs_q2;

  // pulled-up select: anything other than a driven 0 reads as high
  assign sel_hi = (tdi_sel === 1'b0) ? 1'b0 : 1'b1;

  tap_fsm u_fsm (
    .tck   (tck),
    .rst_n (rst_n_i),
    .tms   (tms),
    .state (tap_st)
  );

  tap_ir #(
    .IR_W     (IR_W),
    .CAP_VAL  (IR_CAP),
    .RESET_OP (OP_IDCODE)
  ) u_ir (
    .tck   (tck),
    .rst_n (rst_n_i),
    .state (tap_st),
    .din   (din),
    .ir_sr (ir_sr),
    .ir_q  (ir_q)
  );

  tap_dr #(
    .IR_W      (IR_W),
    .OP_IDCODE (OP_IDCODE),
    .ID_W      (ID_W),
    .ID_VAL    (ID_VAL)
  ) u_dr (
    .tck    (tck),
    .rst_n  (rst_n_i),
    .state  (tap_st),
    .ir_q   (ir_q),
    .din    (din),
    .dr_lsb (dr_lsb)
  );

  alt_sel #(
    .IR_W      (IR_W),
    .OP_IDCODE (OP_IDCODE),
    .RUNS      (ID_RUNS)
  ) u_sel (
    .tck        (tck),
    .rst_n      (rst_n_i),
    .state      (tap_st),
    .ir_sr      (ir_sr),
    .sel_hi     (sel_hi),
    .tdi        (tdi),
    .tdi_alt    (tdi_alt),
    .din        (din),
    .alt_active (alt_active),
    .latched    (alt_latched)
  );

  assign sh_ir = (tap_st == ST_SH_IR);
  assign sh_dr = (tap_st == ST_SH_DR);

  always_comb begin
    tdo_d = 1'b0;
    if (sh_ir)      tdo_d = ir_sr[0];
    else if (sh_dr) tdo_d = dr_lsb;
  end

  always_ff @(negedge tck or negedge rst_n_i) begin
    if (!rst_n_i) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      tdo_q <= tdo_d;
      oe_q  <= sh_ir | sh_dr;
    end
  end

  assign tdo    = tdo_q;
  assign tdo_oe = oe_q;
endmodule

// File: rtl/tap_altsel_chk.sv
`timescale 1ns/1ps
module tap_altsel_chk
  import jtag_alt_pkg::*;
#(
  parameter int unsigned IR_W = 4
) (
  input logic            tck,
  input logic            rst_n,
  input logic            tms,
  input logic            tdi_sel,
  input logic            alt_active,
  input logic            tdo_oe,
  input tap_state_e      state,
  input logic [IR_W-1:0] ir_q,
  input logic            alt_latched
);
  logic [2:0] tms_run;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)              tms_run <= '0;
    else if (!tms)           tms_run <= '0;
    else if (tms_run != 3'd7) tms_run <= tms_run + 3'd1;
  end

  // R2: five TMS-high edges land in Test-Logic-Reset
  a_r2_five_tms_reset: assert property (@(posedge tck) disable iff (!rst_n)
    (tms_run >= 3'd5) |-> (state == ST_RESET));

  // R3: a driven low select forces the alternate input live
  a_r3_sel_low_alt: assert property (@(posedge tck) disable iff (!rst_n)
    (tdi_sel === 1'b0) |-> alt_active);

  // R4: Test-Logic-Reset leaves the identification opcode in the IR
  a_r4_reset_opcode: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_RESET) |=> (ir_q == IR_W'(1)));

  // R7: output enable tracks the two shift states
  a_r7_oe_shift_only: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe == ((state == ST_SH_IR) || (state == ST_SH_DR)));

  // R8: the command latch only sets out of Update-IR
  a_r8_latch_from_update: assert property (@(posedge tck) disable iff (!rst_n)
    $rose(alt_latched) |-> ($past(state) == ST_UPD_IR));

  // R9: Test-Logic-Reset drops the command latch
  a_r9_reset_clears_latch: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_RESET) |=> !alt_latched);
endmodule

bind jtag_tap_altsel tap_altsel_chk #(.IR_W(IR_W)) u_chk (
  .tck         (tck),
  .rst_n       (trst_n),
  .tms         (tms),
  .tdi_sel     (tdi_sel),
  .alt_active  (alt_active),
  .tdo_oe      (tdo_oe),
  .state       (tap_st),
  .ir_q        (ir_q),
  .alt_latched (alt_latched)
);

// File: tb/sim_jtag_tap_altsel.sv
`timescale 1ns/1ps
module sim_jtag_tap_altsel;
  localparam logic [31:0] ID_EXP = 32'h2B6D_904F;
  localparam logic [3:0]  OP_ID  = 4'b0001;
  localparam logic [3:0]  OP_BYP = 4'b1111;
  localparam logic [3:0]  OP_OTH = 4'b0101;

  // {sel, expected alt_active, primary pattern, alternate pattern}
  localparam logic [17:0] VEC [4] = '{
    {1'b1, 1'b0, 8'hA5, 8'h3C},
    {1'b0, 1'b1, 8'hA5, 8'h3C},
    {1'b1, 1'b0, 8'h0F, 8'hF0},
    {1'b0, 1'b1, 8'h96, 8'h69}
  };

  logic tck = 1'b0;
  logic trst_n, tms, tdi, tdi_alt, tdi_sel;
  logic tdo, tdo_oe, alt_active;
  int   n_chk = 0;
  int   n_fail = 0;
  logic done = 1'b0;

  always #2.5 tck = ~tck;

  jtag_tap_altsel #(.IR_W(4), .ID_W(32), .ID_VAL(ID_EXP), .ID_RUNS(4)) u0 (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdi_alt(tdi_alt),
    .tdi_sel(tdi_sel), .tdo(tdo), .tdo_oe(tdo_oe), .alt_active(alt_active)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic m, input logic dp, input logic da,
                     output logic o, output logic e);
    @(negedge tck);
    #0.5;
    o = tdo;
    e = tdo_oe;
    tms = m;
    tdi = dp;
    tdi_alt = da;
    @(posedge tck);
    #0.5;
  endtask

  task automatic load_ir(input logic [3:0] op_p, input logic [3:0] op_a,
                         output logic [3:0] so);
    logic o, e;
    cyc(1'b1, 1'b0, 1'b0, o, e);
    cyc(1'b1, 1'b0, 1'b0, o, e);
    cyc(1'b0, 1'b0, 1'b0, o, e);
    cyc(1'b0, 1'b0, 1'b0, o, e);
    for (int i = 0; i < 4; i++) begin
      cyc(i == 3, op_p[i], op_a[i], o, e);
      so[i] = o;
    end
    cyc(1'b1, 1'b0, 1'b0, o, e);
    cyc(1'b0, 1'b0, 1'b0, o, e);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] p, input logic [63:0] a,
                         output logic [63:0] so, output logic oe_all);
    logic o, e;
    so = '0;
    oe_all = 1'b1;
    cyc(1'b1, 1'b0, 1'b0, o, e);
    cyc(1'b0, 1'b0, 1'b0, o, e);
    cyc(1'b0, 1'b0, 1'b0, o, e);
    for (int i = 0; i < n; i++) begin
      cyc(i == n - 1, p[i], a[i], o, e);
      so[i] = o;
      oe_all = oe_all & e;
    end
    cyc(1'b1, 1'b0, 1'b0, o, e);
    cyc(1'b0, 1'b0, 1'b0, o, e);
  endtask

  task automatic tlr_idle();
    logic o, e;
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 1'b0, o, e);
    cyc(1'b0, 1'b0, 1'b0, o, e);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] so;
    logic [3:0]  iro;
    logic        oe_all, o, e;

    trst_n = 1'b0; tms = 1'b1; tdi = 1'b0; tdi_alt = 1'b0; tdi_sel = 1'b1;
    repeat (4) @(posedge tck);
    #0.5;
    chk("R1 oe in reset", {63'd0, tdo_oe}, 64'd0);
    chk("R1 tdo in reset", {63'd0, tdo}, 64'd0);
    @(negedge tck);
    trst_n = 1'b1;
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b0, o, e);
    chk("R1 alt after reset", {63'd0, alt_active}, 64'd0);
    chk("R1 oe after reset", {63'd0, tdo_oe}, 64'd0);

    // R5: ID read with only TMS/TCK; data pins carry noise
    cyc(1'b0, 1'b0, 1'b0, o, e);
    scan_dr(32, 64'hDEAD_BEEF_1234_5678, 64'h0F0F_F0F0_5A5A_A5A5, so, oe_all);
    chk("R5 idcode after reset", so, {32'd0, ID_EXP});
    chk("R7 oe during shift-dr", {63'd0, oe_all}, 64'd1);
    chk("R7 oe in idle", {63'd0, tdo_oe}, 64'd0);

    // R4: IR capture value reads back during shift-IR
    load_ir(OP_BYP, OP_BYP, iro);
    chk("R4 ir capture", {60'd0, iro}, 64'h1);

    // table walk: select level versus live input (R3, R6)
    for (int v = 0; v < 4; v++) begin
      tlr_idle();
      tdi_sel = VEC[v][17];
      load_ir(OP_BYP, OP_BYP, iro);
      chk("R3 alt_active per select", {63'd0, alt_active}, {63'd0, VEC[v][16]});
      scan_dr(9, {56'd0, VEC[v][15:8]}, {56'd0, VEC[v][7:0]}, so, oe_all);
      chk("R6 bypass path", so,
          {55'd0, (VEC[v][16] ? VEC[v][7:0] : VEC[v][15:8]), 1'b0});
    end
    tdi_sel = 1'b1;

    // R4: non-bypass, non-id opcode behaves as bypass
    tlr_idle();
    load_ir(OP_OTH, OP_OTH, iro);
    scan_dr(5, 64'hB, 64'h4, so, oe_all);
    chk("R4 other opcode bypass", so, {59'd0, 4'hB, 1'b0});

    // R9: reset-loaded id does not count; three loads stay on primary
    tlr_idle();
    for (int i = 0; i < 3; i++) load_ir(OP_ID, OP_ID, iro);
    chk("R9 three loads after reset", {63'd0, alt_active}, 64'd0);
    // R8: fourth consecutive load latches
    load_ir(OP_ID, OP_ID, iro);
    chk("R8 fourth load latches", {63'd0, alt_active}, 64'd1);

    // R9: primary ignored; alt chooses bypass even with id on primary
    load_ir(OP_ID, OP_BYP, iro);
    chk("R9 latch survives other opcode", {63'd0, alt_active}, 64'd1);
    scan_dr(9, 64'hC3, 64'h5A, so, oe_all);
    chk("R9 primary ignored", so, {55'd0, 8'h5A, 1'b0});

    // R2/R9: five TMS from Shift-DR clears latch
    cyc(1'b1, 1'b0, 1'b0, o, e);
    cyc(1'b0, 1'b0, 1'b0, o, e);
    cyc(1'b0, 1'b0, 1'b0, o, e);
    tlr_idle();
    chk("R9 reset clears latch", {63'd0, alt_active}, 64'd0);
    scan_dr(32, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, so, oe_all);
    chk("R2 tlr from shift-dr restores id", so, {32'd0, ID_EXP});

    // R8: run broken by a bypass load restarts
    tlr_idle();
    load_ir(OP_ID, OP_ID, iro);
    load_ir(OP_ID, OP_ID, iro);
    load_ir(OP_BYP, OP_BYP, iro);
    for (int i = 0; i < 3; i++) load_ir(OP_ID, OP_ID, iro);
    chk("R8 broken run stays primary", {63'd0, alt_active}, 64'd0);
    load_ir(OP_ID, OP_ID, iro);
    chk("R8 restarted run latches", {63'd0, alt_active}, 64'd1);

    // R2: five TMS from Shift-IR
    cyc(1'b1, 1'b0, 1'b0, o, e);
    cyc(1'b1, 1'b0, 1'b0, o, e);
    cyc(1'b0, 1'b0, 1'b0, o, e);
    cyc(1'b0, 1'b0, 1'b0, o, e);
    tlr_idle();
    chk("R2 tlr from shift-ir clears", {63'd0, alt_active}, 64'd0);

    // R1: async reset drops a command latch
    for (int i = 0; i < 4; i++) load_ir(OP_ID, OP_ID, iro);
    chk("R8 latch before trst", {63'd0, alt_active}, 64'd1);
    #1;
    trst_n = 1'b0;
    #1;
    chk("R1 trst clears latch", {63'd0, alt_active}, 64'd0);
    chk("R1 trst clears oe", {63'd0, tdo_oe}, 64'd0);
    @(negedge tck);
    trst_n = 1'b1;
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b0, o, e);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule